// File: doc/BRIEF.md
# Power-Capped Per-Core Frequency Allocator

This block chooses an operating frequency level and a supply voltage level for each of four cores so that a global power cap is respected while each core keeps as much of its attainable performance as the cap allows. For every core and every frequency level it receives a predicted performance value (predicted IPC times frequency, fixed point). It also receives one shared table of precomputed peak power per level and one table of the minimum supply voltage code per level. A programmable bound sets how much relative performance loss against the top level a core may give up by choice.

A run starts when the cap input changes value or when a periodic timer expires. The timer counts pulses of a base tick input and fires every `PERIOD_TICKS` of them. A run first gives each core the lowest level whose relative loss stays under the bound. It then removes one level at a time from the core whose next-lower level costs the least relative performance, until the summed peak power fits the cap. Finally it reads each core's voltage from the voltage table. The per-core levels, voltages and a cap-unmet flag are presented together with a one-cycle completion pulse. The performance, power and voltage tables and the bound must be held steady while a run is in progress. The cap is sampled when the run starts.

Top module: `pwr_freq_alloc`

## Requirements
- R1: Levels are numbered upward from 0. The top level (NLVL-1) is the baseline. With a cap that is never exceeded, each core ends on the lowest level L whose predicted performance P(L) either is at least P(top) or satisfies (P(top) - P(L)) * 2^16 < eps * P(top), where eps is an unsigned Q0.16 fraction.
- R2: The bound comparison is strict. A level whose relative loss equals eps exactly is rejected.
- R3: While the summed peak power exceeds the cap, exactly one core drops one level per step. The core chosen is the one whose next-lower level has the smallest relative loss (P(top) - P(L-1)) / P(top), compared by cross-multiplication. Ties go to the lowest-numbered core.
- R4: Trimming stops as soon as the summed peak power is less than or equal to the cap. A sum equal to the cap is accepted.
- R5: A core at level 0 is never chosen for a step-down. If every core is at level 0 and the sum still exceeds the cap, cap_unmet is 1 and all levels are 0. Otherwise cap_unmet is 0.
- R6: Each core's voltage output equals the voltage-table entry at that core's final level.
- R7: A run starts when the cap input differs from its value in the previous cycle, and on every PERIOD_TICKS-th tick pulse (default 10). Changing only the tables or the bound starts no run.
- R8: Each run ends with done high for exactly one cycle. The level, voltage and cap_unmet outputs change only in that cycle and otherwise hold.
- R9: A start condition that arrives while a run is in progress is remembered, and a new run begins in the done cycle. For a run that needs no trimming, the next done comes 4 cycles later.
- R10: While reset is asserted, all levels and voltages are 0, cap_unmet is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base tick pulse that drives the periodic timer |
| cap | input | 12 | Global power cap, same units as the power table |
| eps_q16 | input | 16 | Loss bound, unsigned Q0.16 |
| perf_flat | input | 512 | Predicted performance: core c, level l at bits [(c*8+l)*16 +: 16] |
| pwr_flat | input | 80 | Peak power per level: level l at bits [l*10 +: 10] |
| volt_flat | input | 64 | Minimum voltage code per level: level l at bits [l*8 +: 8] |
| freq_lvl | output | 12 | Chosen level: core c at bits [c*3 +: 3] |
| volt_code | output | 32 | Chosen voltage code: core c at bits [c*8 +: 8] |
| cap_unmet | output | 1 | Cap could not be met with every core at level 0 |
| done | output | 1 | One-cycle run-complete pulse |

## Verification
A wrong initial pick or a wrong step-down choice shows up as a level vector that differs from the hand-derived one in the done cycle of that run. Each run therefore uses performance curves in which the initial pick and the step-down choice lead to different levels, including the exact bound edge, equal-loss ties and losses that are equal in absolute terms but differ in relative terms. A miscounted trim shows at done as a power sum above the cap, or as a core taken one step too low. A lost or doubled trigger shows up as a missing, extra or late done pulse. The timer and the trigger latched during a run are therefore checked by counting done pulses and the cycle gap between them.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

    parameter int NCORE  = 4;
    parameter int NLVL   = 8;
    parameter int PERF_W = 16;
    parameter int PWR_W  = 10;
    parameter int VOLT_W = 8;
    parameter int EPS_W  = 16;

    localparam int LVL_W  = $clog2(NLVL);
    localparam int CORE_W = $clog2(NCORE);
    localparam int SUM_W  = PWR_W + $clog2(NCORE);
    localparam int PROD_W = PERF_W + EPS_W;
    localparam int REL_W  = 2 * PERF_W;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [PERF_W-1:0] perf_t;
    typedef logic [PWR_W-1:0]  pwr_t;
    typedef logic [SUM_W-1:0]  sum_t;
    typedef logic [VOLT_W-1:0] volt_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEL,
        ST_TRIM,
        ST_FIN
    } run_st_e;

    typedef struct packed {
        logic              valid;
        logic [CORE_W-1:0] idx;
    } pick_t;

    // True when level performance p_lvl loses strictly less than eps
    // (Q0.EPS_W) relative to the baseline p_top.
    function automatic logic within_bound(input perf_t p_top,
                                          input perf_t p_lvl,
                                          input logic [EPS_W-1:0] eps);
        logic [PROD_W-1:0] lhs;
        logic [PROD_W-1:0] rhs;
        perf_t             diff;
        if (p_lvl >= p_top) begin
            return 1'b1;
        end
        diff = p_top - p_lvl;
        lhs  = {diff, {EPS_W{1'b0}}};
        rhs  = PROD_W'(eps) * PROD_W'(p_top);
        return lhs < rhs;
    endfunction

    // Absolute loss of p_lvl against p_top, floored at zero.
    function automatic perf_t loss_of(input perf_t p_top, input perf_t p_lvl);
        return (p_lvl >= p_top) ? '0 : perf_t'(p_top - p_lvl);
    endfunction

    // na/da < nb/db without division.
    function automatic logic rel_less(input perf_t na, input perf_t da,
                                      input perf_t nb, input perf_t db);
        logic [REL_W-1:0] l;
        logic [REL_W-1:0] r;
        l = REL_W'(na) * REL_W'(db);
        r = REL_W'(nb) * REL_W'(da);
        return l < r;
    endfunction

endpackage

// File: rtl/pfa_trigger.sv
module pfa_trigger
    import pfa_pkg::*;
#(
    parameter int PERIOD_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  sum_t cap,
    input  logic idle,
    output logic start
);
    localparam int CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;

    sum_t             cap_q;
    logic [CNT_W-1:0] tick_cnt;
    logic             pend;
    logic             tmr_fire;
    logic             evt;

    assign tmr_fire = tick && (tick_cnt == CNT_W'(PERIOD_TICKS - 1));
    assign evt      = (cap != cap_q) || tmr_fire;
    assign start    = idle && (evt || pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q    <= cap;
            tick_cnt <= '0;
            pend     <= 1'b0;
        end else begin
            cap_q <= cap;
            if (tick) begin
                tick_cnt <= tmr_fire ? '0 : tick_cnt + CNT_W'(1);
            end
            if (evt && !idle) begin
                pend <= 1'b1;
            end else if (start) begin
                pend <= 1'b0;
            end
        end
    end

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !idle) |=> pend);

    // R9
    pend_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && idle) |-> start);

endmodule

// File: rtl/pfa_core_select.sv
module pfa_core_select
    import pfa_pkg::*;
(
    input  perf_t              perf [NLVL],
    input  logic [EPS_W-1:0]   eps,
    output lvl_t               init_lvl
);
    always_comb begin
        init_lvl = lvl_t'(NLVL - 1);
        for (int l = NLVL - 1; l >= 0; l--) begin
            if (within_bound(perf[NLVL-1], perf[l], eps)) begin
                init_lvl = lvl_t'(l);
            end
        end
    end
endmodule

// File: rtl/pfa_trim_pick.sv
module pfa_trim_pick
    import pfa_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCORE-1:0][LVL_W-1:0] lvl,
    input  perf_t                       perf [NCORE][NLVL],
    output pick_t                       pick
);
    perf_t num [NCORE];
    perf_t den [NCORE];
    logic  cand [NCORE];

    generate
        for (genvar g = 0; g < NCORE; g++) begin : g_loss
            assign cand[g] = (lvl[g] != '0);
            assign den[g]  = perf[g][NLVL-1];
            assign num[g]  = loss_of(perf[g][NLVL-1], perf[g][lvl[g] - lvl_t'(1)]);
        end
    endgenerate

    always_comb begin
        perf_t best_n;
        perf_t best_d;
        pick   = '0;
        best_n = '0;
        best_d = '0;
        for (int c = 0; c < NCORE; c++) begin
            if (cand[c]) begin
                if (!pick.valid || rel_less(num[c], den[c], best_n, best_d)) begin
                    pick.valid = 1'b1;
                    pick.idx   = CORE_W'(c);
                    best_n     = num[c];
                    best_d     = den[c];
                end
            end
        end
    end

    // R5
    pick_cand_chk: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> (lvl[pick.idx] != '0));

    // R5
    pick_none_chk: assert property (@(posedge clk) disable iff (rst)
        !pick.valid |-> (lvl == '0));

endmodule

// File: rtl/pwr_freq_alloc.sv
module pwr_freq_alloc
    import pfa_pkg::*;
#(
    parameter int PERIOD_TICKS = 10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic [SUM_W-1:0]              cap,
    input  logic [EPS_W-1:0]              eps_q16,
    input  logic [NCORE*NLVL*PERF_W-1:0]  perf_flat,
    input  logic [NLVL*PWR_W-1:0]         pwr_flat,
    input  logic [NLVL*VOLT_W-1:0]        volt_flat,
    output logic [NCORE*LVL_W-1:0]        freq_lvl,
    output logic [NCORE*VOLT_W-1:0]       volt_code,
    output logic                          cap_unmet,
    output logic                          done
);
    perf_t perf_a [NCORE][NLVL];
    pwr_t  pwr_a  [NLVL];
    volt_t volt_a [NLVL];

    generate
        for (genvar l = 0; l < NLVL; l++) begin : g_lvl_tbl
            assign pwr_a[l]  = pwr_flat[l*PWR_W +: PWR_W];
            assign volt_a[l] = volt_flat[l*VOLT_W +: VOLT_W];
            for (genvar c = 0; c < NCORE; c++) begin : g_core_tbl
                assign perf_a[c][l] = perf_flat[(c*NLVL + l)*PERF_W +: PERF_W];
            end
        end
    endgenerate

    run_st_e                      st;
    logic [NCORE-1:0][LVL_W-1:0]  lvl_r;
    logic [NCORE-1:0][LVL_W-1:0]  init_lvl;
    logic [NCORE-1:0][LVL_W-1:0]  out_lvl;
    logic [NCORE-1:0][VOLT_W-1:0] out_volt;
    sum_t                         cap_run;
    sum_t                         sum_now;
    sum_t                         out_sum;
    logic                         fits;
    logic                         unmet_r;
    logic                         start;
    pick_t                        pick;

    pfa_trigger #(.PERIOD_TICKS(PERIOD_TICKS)) u_trig (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .cap   (cap),
        .idle  (st == ST_IDLE),
        .start (start)
    );

    generate
        for (genvar c = 0; c < NCORE; c++) begin : g_sel
            pfa_core_select u_sel (
                .perf     (perf_a[c]),
                .eps      (eps_q16),
                .init_lvl (init_lvl[c])
            );
        end
    endgenerate

    pfa_trim_pick u_pick (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl_r),
        .perf (perf_a),
        .pick (pick)
    );

    always_comb begin
        sum_now = '0;
        out_sum = '0;
        for (int c = 0; c < NCORE; c++) begin
            sum_now = sum_now + sum_t'(pwr_a[lvl_r[c]]);
            out_sum = out_sum + sum_t'(pwr_a[out_lvl[c]]);
        end
    end

    assign fits = (sum_now <= cap_run);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            lvl_r     <= '0;
            cap_run   <= '0;
            unmet_r   <= 1'b0;
            out_lvl   <= '0;
            out_volt  <= '0;
            cap_unmet <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        cap_run <= cap;
                        st      <= ST_SEL;
                    end
                end
                ST_SEL: begin
                    lvl_r   <= init_lvl;
                    unmet_r <= 1'b0;
                    st      <= ST_TRIM;
                end
                ST_TRIM: begin
                    if (fits) begin
                        st <= ST_FIN;
                    end else if (pick.valid) begin
                        lvl_r[pick.idx] <= lvl_r[pick.idx] - lvl_t'(1);
                    end else begin
                        unmet_r <= 1'b1;
                        st      <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    out_lvl <= lvl_r;
                    for (int c = 0; c < NCORE; c++) begin
                        out_volt[c] <= volt_a[lvl_r[c]];
                    end
                    cap_unmet <= unmet_r;
                    done      <= 1'b1;
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign freq_lvl  = out_lvl;
    assign volt_code = out_volt;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(out_lvl) && $stable(out_volt) && $stable(cap_unmet)));

    // R5
    unmet_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cap_unmet) |-> (out_lvl == '0));

    // R4
    cap_met_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !cap_unmet) |-> (out_sum <= cap_run));

    // R3
    trim_one_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRIM && !fits && pick.valid) |=>
            ($countones(lvl_r ^ $past(lvl_r)) >= 1 && $past(lvl_r) > lvl_r));

    generate
        for (genvar c = 0; c < NCORE; c++) begin : g_volt_chk
            // R6
            volt_match_chk: assert property (@(posedge clk) disable iff (rst)
                done |-> (out_volt[c] == volt_a[out_lvl[c]]));
        end
    endgenerate

endmodule

// File: tb/pwr_freq_alloc_bench.sv
module pwr_freq_alloc_bench;
    import pfa_pkg::*;

    logic                         clk = 1'b0;
    logic                         rst;
    logic                         tick;
    logic [SUM_W-1:0]             cap;
    logic [EPS_W-1:0]             eps_q16;
    logic [NCORE*NLVL*PERF_W-1:0] perf_flat;
    logic [NLVL*PWR_W-1:0]        pwr_flat;
    logic [NLVL*VOLT_W-1:0]       volt_flat;
    logic [NCORE*LVL_W-1:0]       freq_lvl;
    logic [NCORE*VOLT_W-1:0]      volt_code;
    logic                         cap_unmet;
    logic                         done;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    int done_cnt = 0;

    always #10 clk = ~clk;

    pwr_freq_alloc u_pwr_freq_alloc (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cap       (cap),
        .eps_q16   (eps_q16),
        .perf_flat (perf_flat),
        .pwr_flat  (pwr_flat),
        .volt_flat (volt_flat),
        .freq_lvl  (freq_lvl),
        .volt_code (volt_code),
        .cap_unmet (cap_unmet),
        .done      (done)
    );

    // sat: {s3,s2,s1,s0}; lvl: {l3,l2,l1,l0}
    typedef struct packed {
        logic [3:0][3:0] sat;
        logic [15:0]     eps;
        logic [11:0]     cap;
        logic [3:0][2:0] lvl;
        logic            unmet;
        logic [3:0]      req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{{4'd6,4'd2,4'd4,4'd8}, 16'd1,     12'd4095, {3'd5,3'd1,3'd3,3'd7}, 1'b0, 4'd1}, // R1
        '{{4'd6,4'd2,4'd4,4'd8}, 16'd1,     12'd300,  {3'd4,3'd1,3'd3,3'd6}, 1'b0, 4'd3}, // R3
        '{{4'd4,4'd4,4'd4,4'd4}, 16'd1,     12'd245,  {3'd3,3'd3,3'd3,3'd2}, 1'b0, 4'd4}, // R4 tie + equality
        '{{4'd6,4'd2,4'd4,4'd8}, 16'd19661, 12'd4094, {3'd4,3'd1,3'd2,3'd5}, 1'b0, 4'd1}, // R1
        '{{4'd4,4'd4,4'd4,4'd4}, 16'd16384, 12'd4095, {3'd3,3'd3,3'd3,3'd3}, 1'b0, 4'd2}, // R2 exact edge
        '{{4'd4,4'd4,4'd4,4'd4}, 16'd16385, 12'd4094, {3'd2,3'd2,3'd2,3'd2}, 1'b0, 4'd2}, // R2 just above
        '{{4'd1,4'd1,4'd1,4'd1}, 16'd1,     12'd50,   {3'd0,3'd0,3'd0,3'd0}, 1'b1, 4'd5}, // R5
        '{{4'd1,4'd1,4'd8,4'd1}, 16'd1,     12'd100,  {3'd0,3'd0,3'd1,3'd0}, 1'b0, 4'd5}, // R5 exclusion
        '{{4'd8,4'd8,4'd8,4'd8}, 16'd1,     12'd70,   {3'd0,3'd0,3'd0,3'd0}, 1'b1, 4'd5}, // R5 full trim
        '{{4'd1,4'd1,4'd8,4'd2}, 16'd1,     12'd185,  {3'd0,3'd0,3'd6,3'd1}, 1'b0, 4'd3}  // R3 relative
    };

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_tables(input logic [3:0][3:0] sat, input logic [15:0] e);
        for (int c = 0; c < NCORE; c++) begin
            for (int l = 0; l < NLVL; l++) begin
                int m;
                m = (l + 1 < int'(sat[c])) ? l + 1 : int'(sat[c]);
                perf_flat[(c*NLVL + l)*PERF_W +: PERF_W] = PERF_W'(100 * m);
            end
        end
        eps_q16 = e;
    endtask

    function automatic logic [NCORE*VOLT_W-1:0] volt_of(input logic [3:0][2:0] lv);
        logic [NCORE*VOLT_W-1:0] v;
        for (int c = 0; c < NCORE; c++) begin
            v[c*VOLT_W +: VOLT_W] = VOLT_W'(80 + 10 * int'(lv[c]));
        end
        return v;
    endfunction

    task automatic wait_done(output logic seen, output int waited);
        seen   = 1'b0;
        waited = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            waited++;
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (done) done_cnt++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic seen;
        int   waited;
        int   base;
        logic [NCORE*LVL_W-1:0]  hold_lvl;
        logic [NCORE*VOLT_W-1:0] hold_volt;

        rst  = 1'b1;
        tick = 1'b0;
        cap  = '0;
        for (int l = 0; l < NLVL; l++) begin
            pwr_flat[l*PWR_W +: PWR_W]    = PWR_W'(20 + 15 * l);
            volt_flat[l*VOLT_W +: VOLT_W] = VOLT_W'(80 + 10 * l);
        end
        load_tables({4'd8,4'd8,4'd8,4'd8}, 16'd1);
        repeat (3) @(negedge clk);

        // R10 reset state
        check(freq_lvl == '0, "R10", "reset levels", 64'(freq_lvl), 64'd0);
        check(volt_code == '0, "R10", "reset volts", 64'(volt_code), 64'd0);
        check(cap_unmet == 1'b0, "R10", "reset unmet", 64'(cap_unmet), 64'd0);
        check(done == 1'b0, "R10", "reset done", 64'(done), 64'd0);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        check(done_cnt == 0, "R7", "no run without event", 64'(done_cnt), 64'd0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[v].req);
            load_tables(VECS[v].sat, VECS[v].eps);
            cap = VECS[v].cap;
            wait_done(seen, waited);
            check(seen, rq, $sformatf("vec%0d done seen", v), 64'(seen), 64'd1);
            check(freq_lvl == VECS[v].lvl, rq, $sformatf("vec%0d levels", v),
                  64'(freq_lvl), 64'(VECS[v].lvl));
            // R6
            check(volt_code == volt_of(VECS[v].lvl), "R6", $sformatf("vec%0d volts", v),
                  64'(volt_code), 64'(volt_of(VECS[v].lvl)));
            check(cap_unmet == VECS[v].unmet, rq, $sformatf("vec%0d unmet", v),
                  64'(cap_unmet), 64'(VECS[v].unmet));
            @(negedge clk);
            // R8 single-cycle pulse
            check(done == 1'b0, "R8", $sformatf("vec%0d done width", v), 64'(done), 64'd0);
            repeat (3) @(negedge clk);
        end

        // R7 / R8: table-only change starts nothing and outputs hold
        hold_lvl  = freq_lvl;
        hold_volt = volt_code;
        base      = done_cnt;
        load_tables({4'd2,4'd2,4'd2,4'd2}, 16'd1);
        repeat (20) @(negedge clk);
        check(done_cnt == base, "R7", "table change no run", 64'(done_cnt - base), 64'd0);
        check(freq_lvl == hold_lvl && volt_code == hold_volt, "R8", "outputs hold",
              64'(freq_lvl), 64'(hold_lvl));

        // R7 periodic timer: nine ticks do nothing, the tenth runs
        for (int k = 0; k < 9; k++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
        check(done_cnt == base, "R7", "nine ticks no run", 64'(done_cnt - base), 64'd0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        wait_done(seen, waited);
        check(seen, "R7", "tenth tick run", 64'(seen), 64'd1);
        check(freq_lvl == {3'd1,3'd1,3'd1,3'd1}, "R7", "timer run levels",
              64'(freq_lvl), 64'({3'd1,3'd1,3'd1,3'd1}));
        repeat (4) @(negedge clk);

        // R9 trigger during a run is latched
        load_tables({4'd8,4'd8,4'd8,4'd8}, 16'd1);
        cap = 12'd70;
        repeat (5) @(negedge clk);
        cap = 12'd4000;
        wait_done(seen, waited);
        check(seen && cap_unmet, "R9", "first run unmet", 64'(cap_unmet), 64'd1);
        wait_done(seen, waited);
        check(seen, "R9", "latched run done", 64'(seen), 64'd1);
        check(waited == 4, "R9", "latched run gap", 64'(waited), 64'd4);
        check(freq_lvl == {3'd7,3'd7,3'd7,3'd7} && !cap_unmet, "R9", "latched run levels",
              64'(freq_lvl), 64'({3'd7,3'd7,3'd7,3'd7}));
        repeat (10) @(negedge clk);
        check(done == 1'b0, "R9", "no extra run", 64'(done), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule